// File: doc/BRIEF.md
# Four-Plane Overlay Compositor with Per-Dot Alpha

The block merges one backdrop video pixel with up to four on-screen-display layers and produces one composited pixel each clock. Every overlay plane supplies a 24-bit RGB colour, a flag saying whether its dot is present, a 6-bit blend weight that may differ from dot to dot, and a 2-bit attribute. A 2-bit stacking code travels with each pixel. It is set per screen region and picks one of four fixed orders in which the planes are stacked.

The compositor first resolves the stacking code into a bottom-to-top list of planes. It then blends upward from the backdrop, one plane per pipeline stage. The result leaves after four registered stages, together with a delayed valid strobe and the attribute of the topmost plane that was present. Colours arrive already in RGB. Palette expansion, colour-space conversion and fetching pixels from memory happen upstream.

Top module: `ovl_compositor`

## Requirements
- R1: While reset is held, out_valid, out_rgb and out_attr are all zero.
- R2: out_valid equals in_valid from exactly four clock cycles earlier. Each accepted pixel appears four cycles after it is presented.
- R3: When no plane has its opaque flag set, out_rgb equals the backdrop colour unchanged and out_attr is 00.
- R4: A present plane with weight w below 63 replaces the result beneath it, channel by channel, with (w*fg + (64-w)*bg) >> 6. The channels are R = bits 23:16, G = bits 15:8 and B = bits 7:0. With w = 0 the colour beneath passes through unchanged.
- R5: A present plane with weight 63 replaces the result beneath it with its own colour exactly.
- R6: Stacking code 0 orders the planes from top to bottom as 3, 2, 1, 0, with the backdrop underneath. Plane k occupies bits [24k+23:24k] of pl_rgb, bits [6k+5:6k] of pl_alpha, bits [2k+1:2k] of pl_attr and bit k of pl_opaque.
- R7: Stacking code 1 orders the planes from top to bottom as 0, 1, 2, 3.
- R8: Stacking code 2 orders the planes from top to bottom as 1, 0, 3, 2.
- R9: Stacking code 3 orders the planes from top to bottom as 2, 3, 0, 1.
- R10: out_attr carries the attribute of the highest plane, in the selected order, whose opaque flag is set, whatever its weight.
- R11: Pixels presented on consecutive cycles, with any stacking codes, are each composited independently of their neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| prio_code | input | 2 | Region stacking code for this pixel |
| bd_rgb | input | 24 | Backdrop colour |
| pl_rgb | input | 96 | Colours of planes 0..3, 24 bits each |
| pl_opaque | input | 4 | Per-plane dot-present flags |
| pl_alpha | input | 24 | Per-plane 6-bit blend weights |
| pl_attr | input | 8 | Per-plane 2-bit attributes |
| out_valid | output | 1 | Output pixel present |
| out_rgb | output | 24 | Composited colour |
| out_attr | output | 2 | Attribute of the topmost present plane |

## Verification
Pixels with every plane absent show that the backdrop passes through bit-exact. A single present plane swept through weights 0, 1, 32 and 62 checks the truncating blend arithmetic. Weight 63 shows that the full-weight case does not lose the one-in-64 residue. For each stacking code, the four planes are set with distinct colours and then at full and at half weight. At full weight only the top plane can show; at half weight each stacking order gives a different result, so a swap of any two positions is detected. Random pixels streamed back to back with gaps in the valid strobe confirm the four-cycle latency and show that neighbouring pixels stay independent.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    parameter int CW   = 8;
    parameter int NCH  = 3;
    parameter int PIXW = CW * NCH;
    parameter int AW   = 6;
    parameter int ATW  = 2;
    parameter int NPL  = 4;
    parameter int PCW  = 2;
    parameter int IDXW = $clog2(NPL);
    parameter int SW   = CW + AW;
    parameter logic [AW-1:0] WMAX  = {AW{1'b1}};
    parameter logic [AW:0]   WFULL = (AW+1)'(1 << AW);

    typedef struct packed {
        logic [PIXW-1:0] rgb;
        logic            opq;
        logic [AW-1:0]   wt;
        logic [ATW-1:0]  attr;
    } layer_t;

    typedef struct packed {
        logic            vld;
        logic [PIXW-1:0] acc;
        logic [ATW-1:0]  attr;
    } stage_t;

    function automatic logic [CW-1:0] mix_ch(input logic [CW-1:0] fg,
                                             input logic [CW-1:0] bg,
                                             input logic [AW-1:0] wt);
        logic [SW-1:0] sum;
        if (wt == WMAX) return fg;
        sum = SW'(wt) * SW'(fg) + SW'(WFULL - {1'b0, wt}) * SW'(bg);
        return CW'(sum >> AW);
    endfunction

    function automatic logic [PIXW-1:0] mix_px(input logic [PIXW-1:0] fg,
                                               input logic [PIXW-1:0] bg,
                                               input logic [AW-1:0]   wt);
        logic [PIXW-1:0] r;
        for (int c = 0; c < NCH; c++)
            r[c*CW +: CW] = mix_ch(fg[c*CW +: CW], bg[c*CW +: CW], wt);
        return r;
    endfunction
endpackage

// File: rtl/ovl_order_map.sv
module ovl_order_map
    import ovl_pkg::*;
(
    input  logic [PCW-1:0]            code,
    output logic [NPL-1:0][IDXW-1:0]  sel
);
    logic [IDXW-1:0] flip;

    // position p (0 = just above backdrop) takes plane p ^ flip
    always_comb begin
        unique case (code)
            2'd0:    flip = IDXW'(0);
            2'd1:    flip = IDXW'(3);
            2'd2:    flip = IDXW'(2);
            default: flip = IDXW'(1);
        endcase
        for (int p = 0; p < NPL; p++)
            sel[p] = IDXW'(p) ^ flip;
    end
endmodule

// File: rtl/ovl_layer_delay.sv
module ovl_layer_delay
    import ovl_pkg::*;
#(
    parameter int DEPTH = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  layer_t d_i,
    output layer_t d_o
);
    layer_t [DEPTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int k = 1; k < DEPTH; k++)
            pipe_d[k] = pipe_q[k-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign d_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/ovl_blend_stage.sv
module ovl_blend_stage
    import ovl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  stage_t st_i,
    input  layer_t lyr_i,
    output stage_t st_o
);
    stage_t st_d, st_q;

    always_comb begin
        st_d = st_i;
        if (lyr_i.opq) begin
            st_d.acc  = mix_px(lyr_i.rgb, st_i.acc, lyr_i.wt);
            st_d.attr = lyr_i.attr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st_o = st_q;
endmodule

// File: rtl/ovl_compositor.sv
module ovl_compositor
    import ovl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [PCW-1:0]        prio_code,
    input  logic [PIXW-1:0]       bd_rgb,
    input  logic [NPL*PIXW-1:0]   pl_rgb,
    input  logic [NPL-1:0]        pl_opaque,
    input  logic [NPL*AW-1:0]     pl_alpha,
    input  logic [NPL*ATW-1:0]    pl_attr,
    output logic                  out_valid,
    output logic [PIXW-1:0]       out_rgb,
    output logic [ATW-1:0]        out_attr
);
    logic [NPL-1:0][IDXW-1:0] sel;
    layer_t [NPL-1:0]         lyr_in;
    layer_t [NPL-1:0]         lyr_al;
    stage_t                   st [NPL+1];

    ovl_order_map u_map (.code(prio_code), .sel(sel));

    always_comb begin
        for (int p = 0; p < NPL; p++) begin
            lyr_in[p].rgb  = pl_rgb[sel[p]*PIXW +: PIXW];
            lyr_in[p].opq  = pl_opaque[sel[p]];
            lyr_in[p].wt   = pl_alpha[sel[p]*AW +: AW];
            lyr_in[p].attr = pl_attr[sel[p]*ATW +: ATW];
        end
        st[0].vld  = in_valid;
        st[0].acc  = bd_rgb;
        st[0].attr = '0;
    end

    for (genvar p = 0; p < NPL; p++) begin : g_pos
        if (p == 0) begin : g_direct
            assign lyr_al[p] = lyr_in[p];
        end else begin : g_delay
            ovl_layer_delay #(.DEPTH(p)) u_dly (
                .clk(clk), .rst_n(rst_n), .d_i(lyr_in[p]), .d_o(lyr_al[p])
            );
        end
        ovl_blend_stage u_stage (
            .clk(clk), .rst_n(rst_n), .st_i(st[p]), .lyr_i(lyr_al[p]), .st_o(st[p+1])
        );
    end

    assign out_valid = st[NPL].vld;
    assign out_rgb   = st[NPL].acc;
    assign out_attr  = st[NPL].attr;
endmodule

// File: rtl/ovl_compositor_chk.sv
module ovl_compositor_chk
    import ovl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [PCW-1:0]   prio_code,
    input logic [PIXW-1:0]  bd_rgb,
    input logic [PIXW-1:0]  top_rgb,
    input logic [AW-1:0]    top_wt,
    input logic [ATW-1:0]   top_attr,
    input logic [NPL-1:0]   pl_opaque,
    input logic             out_valid,
    input logic [PIXW-1:0]  out_rgb,
    input logic [ATW-1:0]   out_attr
);
    logic [2:0] seen_q;
    logic       warm;

    always_ff @(posedge clk) begin
        if (!rst_n)           seen_q <= '0;
        else if (seen_q < 3'd4) seen_q <= seen_q + 3'd1;
    end
    assign warm = (seen_q == 3'd4);

    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        out_valid == $past(in_valid, 4));

    a_r3_backdrop_pass: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        $past(in_valid && pl_opaque == '0, 4) |-> (out_rgb == $past(bd_rgb, 4) && out_attr == '0));

    a_r5_full_weight_top: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        $past(in_valid && prio_code == '0 && pl_opaque[NPL-1] && top_wt == WMAX, 4)
        |-> out_rgb == $past(top_rgb, 4));

    a_r10_top_attr: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        $past(in_valid && prio_code == '0 && pl_opaque[NPL-1], 4)
        |-> out_attr == $past(top_attr, 4));
endmodule

bind ovl_compositor ovl_compositor_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .prio_code(prio_code),
    .bd_rgb(bd_rgb),
    .top_rgb(pl_rgb[ovl_pkg::NPL*ovl_pkg::PIXW-1 -: ovl_pkg::PIXW]),
    .top_wt(pl_alpha[ovl_pkg::NPL*ovl_pkg::AW-1 -: ovl_pkg::AW]),
    .top_attr(pl_attr[ovl_pkg::NPL*ovl_pkg::ATW-1 -: ovl_pkg::ATW]),
    .pl_opaque(pl_opaque), .out_valid(out_valid), .out_rgb(out_rgb), .out_attr(out_attr)
);

// File: tb/tb_ovl_compositor.sv
module tb_ovl_compositor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  prio_code = '0;
    logic [23:0] bd_rgb = '0;
    logic [95:0] pl_rgb = '0;
    logic [3:0]  pl_opaque = '0;
    logic [23:0] pl_alpha = '0;
    logic [7:0]  pl_attr = '0;
    logic        out_valid;
    logic [23:0] out_rgb;
    logic [1:0]  out_attr;

    int checks = 0;
    int fails  = 0;
    logic        h_v   [4];
    logic [25:0] h_exp [4];
    string       h_tag [4];

    always #5 clk = ~clk;

    ovl_compositor dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .prio_code(prio_code),
        .bd_rgb(bd_rgb), .pl_rgb(pl_rgb), .pl_opaque(pl_opaque), .pl_alpha(pl_alpha),
        .pl_attr(pl_attr), .out_valid(out_valid), .out_rgb(out_rgb), .out_attr(out_attr)
    );

    // reference: explicit bottom-to-top plane lists per stacking code
    function automatic logic [25:0] model(input logic [23:0] bd, input logic [95:0] rgb,
                                          input logic [3:0] opq, input logic [23:0] wt,
                                          input logic [7:0] at, input logic [1:0] code);
        int ord [4];
        logic [23:0] acc = bd;
        logic [1:0]  a = 2'b00;
        case (code)
            2'd0: ord = '{0, 1, 2, 3};
            2'd1: ord = '{3, 2, 1, 0};
            2'd2: ord = '{2, 3, 0, 1};
            default: ord = '{1, 0, 3, 2};
        endcase
        for (int p = 0; p < 4; p++) begin
            int i = ord[p];
            if (opq[i]) begin
                int w = int'(wt[i*6 +: 6]);
                for (int c = 0; c < 3; c++) begin
                    int f = int'(rgb[i*24 + c*8 +: 8]);
                    int b = int'(acc[c*8 +: 8]);
                    acc[c*8 +: 8] = (w == 63) ? 8'(f) : 8'((w*f + (64-w)*b) / 64);
                end
                a = at[i*2 +: 2];
            end
        end
        return {acc, a};
    endfunction

    task automatic step(input logic v, input logic [23:0] bd, input logic [95:0] rgb,
                        input logic [3:0] opq, input logic [23:0] wt, input logic [7:0] at,
                        input logic [1:0] code, input string tag);
        @(negedge clk);
        checks++;
        if (out_valid !== h_v[3]) begin
            fails++;
            $display("FAIL R2 (%s): out_valid=%b expected %b", h_tag[3], out_valid, h_v[3]);
        end
        if (h_v[3]) begin
            checks++;
            if ({out_rgb, out_attr} !== h_exp[3]) begin
                fails++;
                $display("FAIL %s: rgb=%h attr=%b expected rgb=%h attr=%b",
                         h_tag[3], out_rgb, out_attr, h_exp[3][25:2], h_exp[3][1:0]);
            end
        end
        for (int k = 3; k > 0; k--) begin
            h_v[k] = h_v[k-1]; h_exp[k] = h_exp[k-1]; h_tag[k] = h_tag[k-1];
        end
        h_v[0] = v; h_exp[0] = model(bd, rgb, opq, wt, at, code); h_tag[0] = tag;
        in_valid = v; bd_rgb = bd; pl_rgb = rgb; pl_opaque = opq;
        pl_alpha = wt; pl_attr = at; prio_code = code;
    endtask

    task automatic flush();
        for (int k = 0; k < 4; k++) step(1'b0, '0, '0, '0, '0, '0, 2'd0, "R2 idle");
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_rgb !== '0 || out_attr !== '0) begin
            fails++;
            $display("FAIL R1: v=%b rgb=%h attr=%b expected 0 0 0", out_valid, out_rgb, out_attr);
        end
        for (int k = 0; k < 4; k++) begin h_v[k] = 1'b0; h_exp[k] = '0; h_tag[k] = "R1"; end
        rst_n = 1'b1;
    endtask

    task automatic t_transparent();
        for (int n = 0; n < 8; n++)
            step(1'b1, 24'($urandom), {$urandom, $urandom, $urandom}, 4'b0000,
                 24'($urandom), 8'($urandom), 2'(n), "R3 backdrop");
        flush();
    endtask

    task automatic t_blend();
        int ws [5] = '{0, 1, 32, 62, 17};
        foreach (ws[n])
            step(1'b1, 24'h00_80_FF, {24'h0, 24'h0, 24'hFF_40_00, 24'h0}, 4'b0010,
                 {12'h0, 6'(ws[n]), 6'h0}, 8'b0000_1100, 2'd0, "R4 blend");
        flush();
    endtask

    task automatic t_full();
        for (int n = 0; n < 4; n++)
            step(1'b1, 24'($urandom), {$urandom, $urandom, $urandom}, 4'b1 << n,
                 {4{6'd63}}, 8'b1110_0100, 2'd0, "R5 full weight");
        flush();
    endtask

    task automatic t_orders();
        string tags [4] = '{"R6 code0", "R7 code1", "R8 code2", "R9 code3"};
        logic [95:0] cols = {24'hE0_10_70, 24'h20_C0_30, 24'h50_60_F0, 24'hA0_A0_08};
        for (int c = 0; c < 4; c++) begin
            step(1'b1, 24'h40_40_40, cols, 4'hF, {4{6'd63}}, 8'b1110_0100, 2'(c), tags[c]);
            step(1'b1, 24'h40_40_40, cols, 4'hF, {4{6'd32}}, 8'b1110_0100, 2'(c), tags[c]);
            step(1'b1, 24'h10_F0_80, cols, 4'hF, {6'd40, 6'd9, 6'd55, 6'd21}, 8'b0110_1100,
                 2'(c), tags[c]);
        end
        flush();
    endtask

    task automatic t_attr();
        for (int n = 0; n < 16; n++)
            step(1'b1, 24'h123456, {$urandom, $urandom, $urandom}, 4'(n),
                 {6'd0, 6'd0, 6'd5, 6'd0}, 8'b1101_1000, 2'(n >> 2), "R10 attr");
        flush();
    endtask

    task automatic t_stream();
        for (int n = 0; n < 300; n++)
            step(($urandom % 5) != 0, 24'($urandom), {$urandom, $urandom, $urandom},
                 4'($urandom), 24'($urandom), 8'($urandom), 2'($urandom), "R11 stream");
        flush();
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        t_reset();
        t_transparent();
        t_blend();
        t_full();
        t_orders();
        t_attr();
        t_stream();
        report();
    end

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        report();
    end
endmodule